// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder

This block turns a stream of 16-bit legacy processor machine code into decoded instruction records. Code bytes arrive one at a time on a valid/ready input. A small phase machine steps through four phases. The first takes the opcode and absorbs any prefixes. The second reads the addressing byte when the opcode needs one. The third counts displacement and immediate bytes. The fourth holds the finished record on the output until the consumer takes it.

Each record carries:
- the operation
- the operand size
- the source and destination operand selectors
- the segment override
- the lock flag
- the repeat mode
- the condition code of a conditional jump
- the total number of bytes the instruction used, prefixes included

Immediate and displacement values are counted but not kept. Execution is left to a later stage.

Back-pressure works as follows. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays high in every phase except the posting phase. While a record waits on the output, `in_ready` is low and input bytes are not consumed. `out_valid` rises in the cycle after the last byte of an instruction is taken. It then holds a stable record until a cycle with `out_ready` high. After that cycle the parser is empty and ready again.

Top module: `idec_top`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low. While `out_valid` is high, `in_ready` is low, input bytes are ignored and every record field holds steady. In the cycle after `out_valid` and `out_ready` are both high, `out_valid` is low and `in_ready` is high. The record appears in the cycle after its last byte is taken, and `out_valid` stays low before that.
- R2: Prefix bytes keep the parser in the opcode phase and apply to the instruction that follows them:
  - 0x26, 0x2E, 0x36 and 0x3E set `out_seg` to 1, 2, 3 and 4, which stand for ES, CS, SS and DS. When several segment prefixes arrive, the last one wins.
  - 0xF0 sets `out_lock`.
  - 0xF2 sets `out_rep`=1 (repeat while not equal).
  - 0xF3 sets `out_rep`=2 (repeat while equal).
  - Once a record is accepted, these fields return to 0 for the next instruction.
- R3: `out_len` counts every byte taken for the instruction, prefixes included, and saturates at 2^LEN_W-1.
- R4: Opcodes 0x00 to 0x3F whose low three bits are 0 to 5 are ALU operations. `out_op` = 1 + opcode[5:3], giving ADD=1, OR=2, ADC=3, SBB=4, AND=5, SUB=6, XOR=7, CMP=8.
  - Low bits 0 to 3 need an addressing byte. Opcode bit 0 sets `out_word`, and opcode bit 1 makes the reg-field operand the destination.
  - Low bits 4 and 5 take a 1-byte immediate into AL or a 2-byte immediate into AX. In that case `out_src` = 21 (immediate).
- R5: Opcodes 0x40 to 0x5F are one-byte word instructions on the register numbered by opcode[2:0]. The register selector is 9 + index (see R9).
  - INC (`out_op`=9) and DEC (10) name the register as both source and destination.
  - PUSH (11) names it as source.
  - POP (12) names it as destination.
- R6: Segment pushes 0x06, 0x0E, 0x16, 0x1E (op 11, source) and pops 0x07, 0x17, 0x1F (op 12, destination) use selectors 17 to 20 for ES, CS, SS, DS. The other one-byte opcodes decode as follows:
  - 0x90 is NOP (18).
  - 0x91 to 0x97 are XCHG (16) with destination AX and source the word register in opcode[2:0].
  - 0x27, 0x2F, 0x37, 0x3F are 19 to 22.
  - 0x98, 0x99 are 23, 24.
  - 0x9B to 0x9F are 26 to 30.
- R7: Opcodes 0x70 to 0x7F are conditional jumps: `out_op`=13, `out_cond` = opcode[3:0], source immediate, byte size. Each takes exactly one displacement byte, so a jump with no prefix has length 2.
- R8: Opcodes 0xB0 to 0xBF are MOV (14) of an immediate into a register. Opcode bit 3 selects word size and a 2-byte immediate. Opcode[2:0] selects the register.
- R9: In the addressing byte, mod is bits [7:6], reg is bits [5:3] and rm is bits [2:0]. Register selectors are:
  - byte registers AL, CL, DL, BL, AH, CH, DH, BH = 1 to 8
  - word registers AX, CX, DX, BX, SP, BP, SI, DI = 9 to 16
  - With mod=3, rm names a register from the same tables and no further bytes follow.
- R10: With mod 0, 1 or 2, rm names a memory operand with selector 22 + rm. The rm values stand for BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. The parser collects 0, 1 or 2 displacement bytes for mod 0, 1 or 2 respectively.
- R11: mod=0 with rm=6 is a direct address (selector 30) followed by 2 address bytes. Opcode 0xA0 loads AL from a direct address, with source 30 and 2 further bytes.
- R12: An unrecognised opcode produces a record with `out_op`=0, and all other fields 0 except `out_len`, which counts the bytes taken. Pending prefixes are discarded.
- R13: The following opcodes all need an addressing byte, and bit 0 of 0x84 to 0x8B selects word size:
  - 0x84/0x85 are TEST (15), with rm as destination.
  - 0x86/0x87 are XCHG (16), with reg as destination.
  - 0x88/0x89 are MOV with rm as destination.
  - 0x8A/0x8B are MOV with reg as destination.
  - 0x8D is LEA (17), word size, reg as destination.
  - 0x8E is a word MOV whose destination is the segment register named by reg[1:0] (selectors 17 to 20).
- R14: 0x9A is a far call (`out_op`=25), word size, source immediate. It collects 4 further bytes, so its length is 5 with no prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Code byte present |
| in_byte | input | 8 | Code byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 5 | Operation code |
| out_word | output | 1 | 1 = word operands, 0 = byte |
| out_src | output | 5 | Source operand selector |
| out_dst | output | 5 | Destination operand selector |
| out_seg | output | 3 | Segment override, 0 = none |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat mode, 0 = none |
| out_cond | output | 4 | Jump condition code |
| out_len | output | LEN_W | Bytes used by the instruction |

## Verification
A wrong phase or a wrong count of remaining operand bytes shows up as a record posted one or more cycles early or late. It also shows up as an `out_len` that differs from the byte count in the stimulus, or as an instruction that swallows the first byte of the next one. All of these are visible at the post following the fault. Prefix state that is not cleared leaks into the segment, lock or repeat fields of the next record and is seen at that record. A fault in posting appears within a cycle as record fields changing under stall, or as `in_ready` high while `out_valid` is high.

// File: rtl/idec_pkg.sv
package idec_pkg;

  typedef enum logic [4:0] {
    OP_INVALID = 5'd0,
    OP_ADD, OP_OR, OP_ADC, OP_SBB, OP_AND, OP_SUB, OP_XOR, OP_CMP,
    OP_INC, OP_DEC, OP_PUSH, OP_POP,
    OP_JCC, OP_MOV, OP_TEST, OP_XCHG, OP_LEA, OP_NOP,
    OP_DAA, OP_DAS, OP_AAA, OP_AAS,
    OP_CBW, OP_CWD, OP_CALLF, OP_WAIT,
    OP_PUSHF, OP_POPF, OP_SAHF, OP_LAHF
  } op_e;

  typedef enum logic [4:0] {
    SEL_NONE = 5'd0,
    SEL_AL, SEL_CL, SEL_DL, SEL_BL, SEL_AH, SEL_CH, SEL_DH, SEL_BH,
    SEL_AX, SEL_CX, SEL_DX, SEL_BX, SEL_SP, SEL_BP, SEL_SI, SEL_DI,
    SEL_ES, SEL_CS, SEL_SS, SEL_DS,
    SEL_IMM,
    SEL_M_BXSI, SEL_M_BXDI, SEL_M_BPSI, SEL_M_BPDI,
    SEL_M_SI, SEL_M_DI, SEL_M_BP, SEL_M_BX,
    SEL_DIRECT
  } sel_e;

  typedef enum logic [2:0] {SEG_NONE, SEG_ES, SEG_CS, SEG_SS, SEG_DS} seg_e;
  typedef enum logic [1:0] {REP_NONE, REP_NE, REP_E} rep_e;
  typedef enum logic [1:0] {PH_OPC, PH_MODRM, PH_OPND, PH_POST} phase_e;
  typedef enum logic [2:0] {K_INVALID, K_PREFIX, K_DONE, K_MODRM, K_OPND} kind_e;
  typedef enum logic [1:0] {F_RM_DST, F_REG_DST, F_SEG_DST} mfmt_e;

  // General register selector: byte regs 1..8, word regs 9..16
  function automatic sel_e gpr_sel(input logic word, input logic [2:0] idx);
    return sel_e'(5'd1 + {1'b0, word, idx});
  endfunction

  // Memory operand selector from rm field: 22..29
  function automatic sel_e mem_sel(input logic [2:0] rm);
    return sel_e'(5'd22 + {2'b00, rm});
  endfunction

  // Segment register selector: 17..20
  function automatic sel_e seg_sel(input logic [1:0] idx);
    return sel_e'(5'd17 + {3'b000, idx});
  endfunction

endpackage

// File: rtl/idec_opmap.sv
module idec_opmap
  import idec_pkg::*;
(
  input  logic [7:0] opc,
  output kind_e      kind,
  output op_e        op,
  output logic       word,
  output sel_e       src,
  output sel_e       dst,
  output mfmt_e      fmt,
  output logic [2:0] imm_n,
  output logic [3:0] cond,
  output seg_e       pseg,
  output logic       plock,
  output rep_e       prep
);

  op_e alu_op;
  assign alu_op = op_e'(5'd1 + {2'b00, opc[5:3]});

  always_comb begin
    kind  = K_INVALID;
    op    = OP_INVALID;
    word  = 1'b0;
    src   = SEL_NONE;
    dst   = SEL_NONE;
    fmt   = F_RM_DST;
    imm_n = 3'd0;
    cond  = 4'd0;
    pseg  = SEG_NONE;
    plock = 1'b0;
    prep  = REP_NONE;
    casez (opc)
      8'b00???0??: begin
        kind = K_MODRM;
        op   = alu_op;
        word = opc[0];
        fmt  = opc[1] ? F_REG_DST : F_RM_DST;
      end
      8'b00???10?: begin
        kind  = K_OPND;
        op    = alu_op;
        word  = opc[0];
        src   = SEL_IMM;
        dst   = opc[0] ? SEL_AX : SEL_AL;
        imm_n = opc[0] ? 3'd2 : 3'd1;
      end
      8'b00???11?: begin
        if (!opc[5]) begin
          if (!(opc[4:3] == 2'd1 && opc[0])) begin
            kind = K_DONE;
            word = 1'b1;
            if (!opc[0]) begin
              op  = OP_PUSH;
              src = seg_sel(opc[4:3]);
            end else begin
              op  = OP_POP;
              dst = seg_sel(opc[4:3]);
            end
          end
        end else if (!opc[0]) begin
          kind = K_PREFIX;
          pseg = seg_e'(3'd1 + {1'b0, opc[4:3]});
        end else begin
          kind = K_DONE;
          op   = op_e'(5'd19 + {3'b000, opc[4:3]});
        end
      end
      8'b010?????: begin
        kind = K_DONE;
        word = 1'b1;
        op   = op_e'(5'd9 + {3'b000, opc[4:3]});
        case (opc[4:3])
          2'd2:    src = gpr_sel(1'b1, opc[2:0]);
          2'd3:    dst = gpr_sel(1'b1, opc[2:0]);
          default: begin
            src = gpr_sel(1'b1, opc[2:0]);
            dst = gpr_sel(1'b1, opc[2:0]);
          end
        endcase
      end
      8'b0111????: begin
        kind  = K_OPND;
        op    = OP_JCC;
        src   = SEL_IMM;
        imm_n = 3'd1;
        cond  = opc[3:0];
      end
      8'b100001??: begin
        kind = K_MODRM;
        op   = opc[1] ? OP_XCHG : OP_TEST;
        word = opc[0];
        fmt  = opc[1] ? F_REG_DST : F_RM_DST;
      end
      8'b100010??: begin
        kind = K_MODRM;
        op   = OP_MOV;
        word = opc[0];
        fmt  = opc[1] ? F_REG_DST : F_RM_DST;
      end
      8'h8D: begin
        kind = K_MODRM;
        op   = OP_LEA;
        word = 1'b1;
        fmt  = F_REG_DST;
      end
      8'h8E: begin
        kind = K_MODRM;
        op   = OP_MOV;
        word = 1'b1;
        fmt  = F_SEG_DST;
      end
      8'h90: begin
        kind = K_DONE;
        op   = OP_NOP;
      end
      8'b10010???: begin
        kind = K_DONE;
        op   = OP_XCHG;
        word = 1'b1;
        dst  = SEL_AX;
        src  = gpr_sel(1'b1, opc[2:0]);
      end
      8'h98: begin kind = K_DONE; op = OP_CBW;  end
      8'h99: begin kind = K_DONE; op = OP_CWD;  end
      8'h9A: begin
        kind  = K_OPND;
        op    = OP_CALLF;
        word  = 1'b1;
        src   = SEL_IMM;
        imm_n = 3'd4;
      end
      8'h9B: begin kind = K_DONE; op = OP_WAIT;  end
      8'h9C: begin kind = K_DONE; op = OP_PUSHF; end
      8'h9D: begin kind = K_DONE; op = OP_POPF;  end
      8'h9E: begin kind = K_DONE; op = OP_SAHF;  end
      8'h9F: begin kind = K_DONE; op = OP_LAHF;  end
      8'hA0: begin
        kind  = K_OPND;
        op    = OP_MOV;
        src   = SEL_DIRECT;
        dst   = SEL_AL;
        imm_n = 3'd2;
      end
      8'b1011????: begin
        kind  = K_OPND;
        op    = OP_MOV;
        word  = opc[3];
        src   = SEL_IMM;
        dst   = gpr_sel(opc[3], opc[2:0]);
        imm_n = opc[3] ? 3'd2 : 3'd1;
      end
      8'hF0: begin kind = K_PREFIX; plock = 1'b1; end
      8'hF2: begin kind = K_PREFIX; prep = REP_NE; end
      8'hF3: begin kind = K_PREFIX; prep = REP_E;  end
      default: kind = K_INVALID;
    endcase
  end

endmodule

// File: rtl/idec_modrm.sv
module idec_modrm
  import idec_pkg::*;
(
  input  logic [7:0] modrm,
  input  logic       word,
  input  mfmt_e      fmt,
  output sel_e       src,
  output sel_e       dst,
  output logic [1:0] disp_n
);

  logic [1:0] md;
  logic [2:0] rg;
  logic [2:0] rm;
  sel_e       rm_opnd;
  sel_e       rg_opnd;

  assign md = modrm[7:6];
  assign rg = modrm[5:3];
  assign rm = modrm[2:0];

  always_comb begin
    if (md == 2'd3)
      rm_opnd = gpr_sel(word, rm);
    else if (md == 2'd0 && rm == 3'd6)
      rm_opnd = SEL_DIRECT;
    else
      rm_opnd = mem_sel(rm);

    case (md)
      2'd0:    disp_n = (rm == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    disp_n = 2'd1;
      2'd2:    disp_n = 2'd2;
      default: disp_n = 2'd0;
    endcase

    rg_opnd = (fmt == F_SEG_DST) ? seg_sel(rg[1:0]) : gpr_sel(word, rg);

    if (fmt == F_RM_DST) begin
      dst = rm_opnd;
      src = rg_opnd;
    end else begin
      dst = rg_opnd;
      src = rm_opnd;
    end
  end

endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [4:0]       out_op,
  output logic             out_word,
  output logic [4:0]       out_src,
  output logic [4:0]       out_dst,
  output logic [2:0]       out_seg,
  output logic             out_lock,
  output logic [1:0]       out_rep,
  output logic [3:0]       out_cond,
  output logic [LEN_W-1:0] out_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  phase_e           phase_q;
  op_e              op_q;
  logic             word_q;
  sel_e             src_q, dst_q;
  seg_e             seg_q;
  logic             lock_q;
  rep_e             rep_q;
  logic [3:0]       cond_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       left_q;
  mfmt_e            fmt_q;

  kind_e      m_kind;
  op_e        m_op;
  logic       m_word;
  sel_e       m_src, m_dst;
  mfmt_e      m_fmt;
  logic [2:0] m_imm;
  logic [3:0] m_cond;
  seg_e       m_pseg;
  logic       m_plock;
  rep_e       m_prep;

  sel_e       r_src, r_dst;
  logic [1:0] r_disp;

  logic             take;
  logic [LEN_W-1:0] len_nxt;

  idec_opmap u_opmap (
    .opc   (in_byte),
    .kind  (m_kind),
    .op    (m_op),
    .word  (m_word),
    .src   (m_src),
    .dst   (m_dst),
    .fmt   (m_fmt),
    .imm_n (m_imm),
    .cond  (m_cond),
    .pseg  (m_pseg),
    .plock (m_plock),
    .prep  (m_prep)
  );

  idec_modrm u_modrm (
    .modrm  (in_byte),
    .word   (word_q),
    .fmt    (fmt_q),
    .src    (r_src),
    .dst    (r_dst),
    .disp_n (r_disp)
  );

  assign in_ready  = (phase_q != PH_POST);
  assign out_valid = (phase_q == PH_POST);
  assign take      = in_valid && in_ready;
  assign len_nxt   = (len_q == LEN_MAX) ? len_q : len_q + 1'b1;

  assign out_op   = op_q;
  assign out_word = word_q;
  assign out_src  = src_q;
  assign out_dst  = dst_q;
  assign out_seg  = seg_q;
  assign out_lock = lock_q;
  assign out_rep  = rep_q;
  assign out_cond = cond_q;
  assign out_len  = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n || (phase_q == PH_POST && out_ready)) begin
      phase_q <= PH_OPC;
      op_q    <= OP_INVALID;
      word_q  <= 1'b0;
      src_q   <= SEL_NONE;
      dst_q   <= SEL_NONE;
      seg_q   <= SEG_NONE;
      lock_q  <= 1'b0;
      rep_q   <= REP_NONE;
      cond_q  <= 4'd0;
      len_q   <= '0;
      left_q  <= 3'd0;
      fmt_q   <= F_RM_DST;
    end else if (take) begin
      len_q <= len_nxt;
      case (phase_q)
        PH_OPC: begin
          case (m_kind)
            K_PREFIX: begin
              if (m_pseg != SEG_NONE) seg_q  <= m_pseg;
              if (m_plock)            lock_q <= 1'b1;
              if (m_prep != REP_NONE) rep_q  <= m_prep;
            end
            K_INVALID: begin
              op_q    <= OP_INVALID;
              seg_q   <= SEG_NONE;
              lock_q  <= 1'b0;
              rep_q   <= REP_NONE;
              phase_q <= PH_POST;
            end
            K_MODRM: begin
              op_q    <= m_op;
              word_q  <= m_word;
              fmt_q   <= m_fmt;
              phase_q <= PH_MODRM;
            end
            default: begin
              op_q    <= m_op;
              word_q  <= m_word;
              src_q   <= m_src;
              dst_q   <= m_dst;
              cond_q  <= m_cond;
              left_q  <= m_imm;
              phase_q <= (m_kind == K_OPND) ? PH_OPND : PH_POST;
            end
          endcase
        end
        PH_MODRM: begin
          src_q   <= r_src;
          dst_q   <= r_dst;
          left_q  <= {1'b0, r_disp};
          phase_q <= (r_disp == 2'd0) ? PH_POST : PH_OPND;
        end
        PH_OPND: begin
          left_q <= left_q - 3'd1;
          if (left_q == 3'd1) phase_q <= PH_POST;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/idec_chk.sv
module idec_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [4:0]       out_op,
  input logic             out_word,
  input logic [4:0]       out_src,
  input logic [4:0]       out_dst,
  input logic [2:0]       out_seg,
  input logic             out_lock,
  input logic [1:0]       out_rep,
  input logic [LEN_W-1:0] out_len
);

  // R1: no byte is taken while a record is waiting
  a_r1_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1: a stalled record holds every field
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_len)
      && $stable(out_src) && $stable(out_dst) && $stable(out_seg)
      && $stable(out_lock) && $stable(out_rep) && $stable(out_word));

  // R1: an accepted record frees the parser in the next cycle
  a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  // R3: every record used at least one byte
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != '0);

  // R12: invalid records carry no prefix state
  a_r12_invalid_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 5'd0 |-> out_seg == 3'd0 && !out_lock && out_rep == 2'd0
      && out_src == 5'd0 && out_dst == 5'd0);

  // R7: conditional jumps take an immediate displacement in byte size
  a_r7_jump_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 5'd13 |-> out_src == 5'd21 && !out_word && out_dst == 5'd0);

endmodule

bind idec_top idec_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_word  (out_word),
  .out_src   (out_src),
  .out_dst   (out_dst),
  .out_seg   (out_seg),
  .out_lock  (out_lock),
  .out_rep   (out_rep),
  .out_len   (out_len)
);

// File: tb/sim_idec_top.sv
`timescale 1ns/1ps
module sim_idec_top;

  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             in_ready;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [4:0]       out_op;
  logic             out_word;
  logic [4:0]       out_src;
  logic [4:0]       out_dst;
  logic [2:0]       out_seg;
  logic             out_lock;
  logic [1:0]       out_rep;
  logic [3:0]       out_cond;
  logic [LEN_W-1:0] out_len;

  int checks = 0;
  int fails  = 0;
  logic [7:0] seq [0:23];
  int seq_n = 0;

  always #10 clk = ~clk;

  idec_top #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_word(out_word), .out_src(out_src), .out_dst(out_dst),
    .out_seg(out_seg), .out_lock(out_lock), .out_rep(out_rep),
    .out_cond(out_cond), .out_len(out_len)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    seq[seq_n] = b;
    seq_n++;
  endtask

  // Drive queued bytes one per cycle; no record may appear before the last one (R1)
  task automatic feed(input string req);
    for (int i = 0; i < seq_n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = seq[i];
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      if (i != seq_n - 1) chk(req, "early out_valid (R1)", int'(out_valid), 0);
    end
    seq_n = 0;
  endtask

  task automatic expect_rec(input string req, input int op, input int word, input int src,
                            input int dst, input int seg, input int lock, input int rep,
                            input int cond, input int len, input bit stall);
    @(negedge clk);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_op", int'(out_op), op);
    chk(req, "out_word", int'(out_word), word);
    chk(req, "out_src", int'(out_src), src);
    chk(req, "out_dst", int'(out_dst), dst);
    chk(req, "out_seg", int'(out_seg), seg);
    chk(req, "out_lock", int'(out_lock), lock);
    chk(req, "out_rep", int'(out_rep), rep);
    chk(req, "out_cond", int'(out_cond), cond);
    chk(req, "out_len", int'(out_len), len);
    if (stall) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R1", "in_ready under stall", int'(in_ready), 0);
        chk("R1", "out_op under stall", int'(out_op), op);
        chk("R1", "out_len under stall", int'(out_len), len);
      end
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
    chk("R1", "out_valid after accept", int'(out_valid), 0);
    chk("R1", "in_ready after accept", int'(in_ready), 1);
  endtask

  task automatic t_reset();
    chk("R1", "in_ready at reset", int'(in_ready), 1);
    chk("R1", "out_valid at reset", int'(out_valid), 0);
  endtask

  task automatic t_alu();
    put(8'h00); put(8'hC1); feed("R4");
    expect_rec("R4 R9 add reg-reg", 1, 0, 1, 2, 0, 0, 0, 0, 2, 1'b0);
    put(8'h03); put(8'h46); put(8'h10); feed("R10");
    expect_rec("R10 add bp+d8", 1, 1, 28, 9, 0, 0, 0, 0, 3, 1'b0);
    put(8'h2D); put(8'h34); put(8'h12); feed("R4");
    expect_rec("R4 sub ax imm", 6, 1, 21, 9, 0, 0, 0, 0, 3, 1'b0);
    put(8'h3C); put(8'h05); feed("R4");
    expect_rec("R4 cmp al imm", 8, 0, 21, 1, 0, 0, 0, 0, 2, 1'b0);
    put(8'h2B); put(8'h87); put(8'h00); put(8'h01); feed("R10");
    expect_rec("R10 sub bx+d16", 6, 1, 29, 9, 0, 0, 0, 0, 4, 1'b0);
    put(8'h8B); put(8'h00); feed("R10");
    expect_rec("R10 mov bx+si no disp", 14, 1, 22, 9, 0, 0, 0, 0, 2, 1'b0);
  endtask

  task automatic t_direct();
    put(8'h8A); put(8'h06); put(8'h00); put(8'h10); feed("R11");
    expect_rec("R11 mov al direct", 14, 0, 30, 1, 0, 0, 0, 0, 4, 1'b0);
    put(8'hA0); put(8'h34); put(8'h12); feed("R11");
    expect_rec("R11 A0 form", 14, 0, 30, 1, 0, 0, 0, 0, 3, 1'b0);
  endtask

  task automatic t_regs();
    put(8'h43); feed("R5");
    expect_rec("R5 inc bx", 9, 1, 12, 12, 0, 0, 0, 0, 1, 1'b0);
    put(8'h4F); feed("R5");
    expect_rec("R5 dec di", 10, 1, 16, 16, 0, 0, 0, 0, 1, 1'b0);
    put(8'h55); feed("R5");
    expect_rec("R5 push bp", 11, 1, 14, 0, 0, 0, 0, 0, 1, 1'b0);
    put(8'h5E); feed("R5");
    expect_rec("R5 pop si", 12, 1, 0, 15, 0, 0, 0, 0, 1, 1'b0);
  endtask

  task automatic t_single();
    put(8'h06); feed("R6");
    expect_rec("R6 push es", 11, 1, 17, 0, 0, 0, 0, 0, 1, 1'b0);
    put(8'h1F); feed("R6");
    expect_rec("R6 pop ds", 12, 1, 0, 20, 0, 0, 0, 0, 1, 1'b0);
    put(8'h90); feed("R6");
    expect_rec("R6 nop", 18, 0, 0, 0, 0, 0, 0, 0, 1, 1'b0);
    put(8'h93); feed("R6");
    expect_rec("R6 xchg ax bx", 16, 1, 12, 9, 0, 0, 0, 0, 1, 1'b0);
    put(8'h37); feed("R6");
    expect_rec("R6 aaa", 21, 0, 0, 0, 0, 0, 0, 0, 1, 1'b0);
    put(8'h9F); feed("R6");
    expect_rec("R6 lahf", 30, 0, 0, 0, 0, 0, 0, 0, 1, 1'b0);
  endtask

  task automatic t_jump();
    put(8'h74); put(8'hFE); feed("R7");
    expect_rec("R7 jump cond 4", 13, 0, 21, 0, 0, 0, 0, 4, 2, 1'b0);
    put(8'h7F); put(8'h00); feed("R7");
    expect_rec("R7 jump cond 15", 13, 0, 21, 0, 0, 0, 0, 15, 2, 1'b0);
  endtask

  task automatic t_movi();
    put(8'hB4); put(8'h12); feed("R8");
    expect_rec("R8 mov ah imm", 14, 0, 21, 5, 0, 0, 0, 0, 2, 1'b0);
    put(8'hBE); put(8'h34); put(8'h12); feed("R8");
    expect_rec("R8 mov si imm", 14, 1, 21, 15, 0, 0, 0, 0, 3, 1'b0);
  endtask

  task automatic t_prefix();
    put(8'h26); put(8'hF0); put(8'hF3); put(8'h89); put(8'hD8); feed("R2");
    expect_rec("R2 R3 R9 prefixed mov", 14, 1, 12, 9, 1, 1, 2, 0, 5, 1'b0);
    put(8'h90); feed("R2");
    expect_rec("R2 prefixes cleared", 18, 0, 0, 0, 0, 0, 0, 0, 1, 1'b0);
    put(8'h2E); put(8'h3E); put(8'hF2); put(8'h50); feed("R2");
    expect_rec("R2 last segment wins", 11, 1, 9, 0, 4, 0, 1, 0, 4, 1'b0);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) put(8'hF0);
    put(8'h90);
    feed("R3");
    expect_rec("R3 length saturates", 18, 0, 0, 0, 0, 1, 0, 0, 15, 1'b0);
  endtask

  task automatic t_invalid();
    put(8'hF2); put(8'h26); put(8'h0F); feed("R12");
    expect_rec("R12 invalid after prefixes", 0, 0, 0, 0, 0, 0, 0, 0, 3, 1'b0);
    put(8'h48); feed("R12");
    expect_rec("R12 prefixes dropped", 10, 1, 9, 9, 0, 0, 0, 0, 1, 1'b0);
    put(8'h62); feed("R12");
    expect_rec("R12 invalid alone", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1'b0);
  endtask

  task automatic t_modrm_misc();
    put(8'h8E); put(8'hD8); feed("R13");
    expect_rec("R13 mov to ds", 14, 1, 9, 20, 0, 0, 0, 0, 2, 1'b0);
    put(8'h8D); put(8'h47); put(8'h04); feed("R13");
    expect_rec("R13 lea", 17, 1, 29, 9, 0, 0, 0, 0, 3, 1'b0);
    put(8'h84); put(8'hC3); feed("R13");
    expect_rec("R13 test bl al", 15, 0, 1, 4, 0, 0, 0, 0, 2, 1'b0);
    put(8'h87); put(8'hCA); feed("R13");
    expect_rec("R13 xchg cx dx", 16, 1, 11, 10, 0, 0, 0, 0, 2, 1'b0);
  endtask

  task automatic t_callf();
    put(8'h9A); put(8'h00); put(8'h01); put(8'h00); put(8'h20); feed("R14");
    expect_rec("R14 far call", 25, 1, 21, 0, 0, 0, 0, 0, 5, 1'b0);
  endtask

  task automatic t_stall();
    put(8'h40); feed("R1");
    // Offer a byte while the record waits; it must be ignored
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'hF3;
    expect_rec("R1 stalled inc ax", 9, 1, 9, 9, 0, 0, 0, 0, 1, 1'b1);
    in_valid = 1'b0;
    put(8'h48); feed("R1");
    expect_rec("R1 byte under stall ignored", 10, 1, 9, 9, 0, 0, 0, 0, 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_direct();
    t_regs();
    t_single();
    t_jump();
    t_movi();
    t_prefix();
    t_sat();
    t_invalid();
    t_modrm_misc();
    t_callf();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule